// File: doc/BRIEF.md
# Flash Array Controller with Erase Sequencer

This block fronts a word-addressed NOR-style flash array and a 64-word user configuration bank. Both are held in on-chip storage. A 32-bit register port carries the controls: a two-bit configuration register, a ready flag, two page-erase address registers, a whole-chip erase command and a user-bank erase command. A second port reads and programs the flash array. A third port reads and writes the user bank.

Programming follows NOR rules. The stored word becomes the AND of the old word and the new word, so a bit can only go from one to zero. Only an erase brings bits back to one. Every erase runs as a sequencer that fills one word per clock with all ones. While a fill runs, the ready flag reads zero and the data ports and erase commands are held off through their ready outputs.

All accesses are whole 32-bit words in little-endian byte order. The default geometry is kept small: 8 pages of 1024 bytes. Set `NUM_PAGES` to 256 for a 256 KiB array.

Top module: `flash_ctl`

## Requirements
- R1: After reset the configuration reads 0, the ready register reads 1, every user-bank word reads 0xFFFFFFFF, and both `bad_acc_o` and `prog_err_o` are 0.
- R2: Register offset 0x04 is the configuration. Bit 0 enables programming and bit 1 enables erasing. The other written bits are dropped, so they read back as 0.
- R3: When programming is enabled, a flash-port write stores the AND of the old and new word. When it is disabled, the write leaves the array unchanged and sets the sticky `prog_err_o`.
- R4: A write to offset 0x08 or 0x0C is a byte address. Its in-page bits are dropped to find the page. That page is filled with ones only when erasing is enabled and the page lies inside the array; in every other case nothing changes.
- R5: Writing 0x00000001 to offset 0x10 while erasing is enabled fills the whole flash array and the whole user bank with ones. Any other value, or erasing disabled, has no effect.
- R6: Writing 0x00000001 to offset 0x14 fills the user bank with ones whatever the configuration. Any other value has no effect.
- R7: A user-port write replaces the stored word outright. Flash-port and user-port reads return the word one cycle after the request is accepted.
- R8: Offsets 0x08–0x14 are write-only and read as 0. A write to offset 0x00 is ignored. Any access to another offset, or to an offset whose low two bits are not zero, reads 0, changes nothing and sets the sticky `bad_acc_o`.
- R9: While a fill runs, `fl_rdy_o` and `ub_rdy_o` are low, the ready register (offset 0x00) reads 0, and a write to an erase register is held with `reg_rdy_o` low.
- R10: A fill keeps the block busy for exactly one cycle per word written: 256 cycles for a page, 64 for the user bank, and the number of flash words for a chip erase. After that the ready register reads 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Register write (1) or read (0) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdy_o | output | 1 | Register access accepted this cycle |
| reg_rdata_o | output | 32 | Register read data, one cycle after acceptance |
| fl_req_i | input | 1 | Flash access request |
| fl_we_i | input | 1 | Flash program (1) or read (0) |
| fl_addr_i | input | FA_W | Flash word address |
| fl_wdata_i | input | 32 | Program data |
| fl_rdy_o | output | 1 | Flash port free (no fill running) |
| fl_rdata_o | output | 32 | Flash read data |
| ub_req_i | input | 1 | User-bank access request |
| ub_we_i | input | 1 | User-bank write (1) or read (0) |
| ub_addr_i | input | 6 | User-bank word address |
| ub_wdata_i | input | 32 | User-bank write data |
| ub_rdy_o | output | 1 | User port free (no fill running) |
| ub_rdata_o | output | 32 | User-bank read data |
| bad_acc_o | output | 1 | Sticky undefined-register-access flag |
| prog_err_o | output | 1 | Sticky rejected-program flag |

## Verification
A sequencer whose pointer or end index goes wrong shows up at the ports in two ways. The busy window seen on `fl_rdy_o` has the wrong length, which is visible the cycle the fill should end. The words just outside an erased page are found changed, or words inside it are left unchanged, on the first read after ready returns. A configuration bit that is lost or stuck shows up in two places: the next read of offset 0x04, or the next program or erase, which is then applied or dropped against the requirement. The sticky flags can be checked on the cycle after the access that should set them.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  typedef enum logic [1:0] {ER_PAGE, ER_CHIP, ER_USER} erase_kind_e;

  localparam logic [7:0]  OFF_READY = 8'h00;
  localparam logic [7:0]  OFF_CFG   = 8'h04;
  localparam logic [7:0]  OFF_PG_A  = 8'h08;
  localparam logic [7:0]  OFF_PG_B  = 8'h0C;
  localparam logic [7:0]  OFF_CHIP  = 8'h10;
  localparam logic [7:0]  OFF_USER  = 8'h14;
  localparam logic [31:0] ERASE_KEY = 32'h0000_0001;
  localparam int          UB_WORDS  = 64;
endpackage

// File: rtl/flash_ctl_mem.sv
module flash_ctl_mem #(
  parameter int WORDS      = 64,
  parameter bit RESET_ONES = 1'b0,
  localparam int AW        = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          and_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [WORDS];
  logic [31:0] wval;

  // NOR programming: only 1->0 transitions when and_i is set
  assign wval = and_i ? (mem_q[waddr_i] & wdata_i) : wdata_i;

  generate
    if (RESET_ONES) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else if (we_i) begin
          mem_q[waddr_i] <= wval;
        end
      end
    end else begin : g_nrst
      always_ff @(posedge clk_i) begin
        if (we_i) mem_q[waddr_i] <= wval;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/flash_ctl_erase_seq.sv
module flash_ctl_erase_seq
  import flash_ctl_pkg::*;
#(
  parameter int FLASH_WORDS = 2048,
  parameter int PAGE_WORDS  = 256,
  localparam int FA_W       = $clog2(FLASH_WORDS),
  localparam int PW_W       = $clog2(PAGE_WORDS),
  localparam int PG_W       = FA_W - PW_W,
  localparam int UA_W       = $clog2(UB_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  erase_kind_e     kind_i,
  input  logic [PG_W-1:0] page_i,
  output logic            busy_o,
  output logic            fl_we_o,
  output logic [FA_W-1:0] fl_addr_o,
  output logic            ub_we_o,
  output logic [UA_W-1:0] ub_addr_o
);
  logic            busy_q;
  erase_kind_e     kind_q;
  logic [FA_W-1:0] ptr_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= ER_PAGE;
      ptr_q  <= '0;
      last_q <= '0;
    end else if (busy_q) begin
      if (ptr_q == last_q) busy_q <= 1'b0;
      else                 ptr_q  <= ptr_q + 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      kind_q <= kind_i;
      unique case (kind_i)
        ER_PAGE: begin
          ptr_q  <= {page_i, {PW_W{1'b0}}};
          last_q <= {page_i, {PW_W{1'b1}}};
        end
        ER_CHIP: begin
          ptr_q  <= '0;
          last_q <= FA_W'(FLASH_WORDS - 1);
        end
        default: begin
          ptr_q  <= '0;
          last_q <= FA_W'(UB_WORDS - 1);
        end
      endcase
    end
  end

  assign busy_o    = busy_q;
  assign fl_we_o   = busy_q && (kind_q != ER_USER);
  assign fl_addr_o = ptr_q;
  // chip erase clears the user bank alongside the first UB_WORDS flash words
  assign ub_we_o   = busy_q && ((kind_q == ER_USER) ||
                     ((kind_q == ER_CHIP) && (ptr_q < FA_W'(UB_WORDS))));
  assign ub_addr_o = ptr_q[UA_W-1:0];
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
  import flash_ctl_pkg::*;
#(
  parameter int NUM_PAGES  = 8,
  parameter int PAGE_BYTES = 1024,
  localparam int PB_W      = $clog2(PAGE_BYTES),
  localparam int PG_W      = $clog2(NUM_PAGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [7:0]      addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            busy_i,
  input  logic            prog_rej_i,
  output logic            rdy_o,
  output logic [31:0]     rdata_o,
  output logic            wen_o,
  output logic            een_o,
  output logic            start_o,
  output erase_kind_e     kind_o,
  output logic [PG_W-1:0] page_o,
  output logic            bad_acc_o,
  output logic            prog_err_o
);
  logic [1:0]       cfg_q;
  logic             is_erase, known, acc, in_range;
  logic [31-PB_W:0] pg_hi;

  assign is_erase = (addr_i == OFF_PG_A) || (addr_i == OFF_PG_B) ||
                    (addr_i == OFF_CHIP) || (addr_i == OFF_USER);
  assign known    = is_erase || (addr_i == OFF_READY) || (addr_i == OFF_CFG);
  assign rdy_o    = !(busy_i && we_i && is_erase);
  assign acc      = req_i && rdy_o;

  assign pg_hi    = wdata_i[31:PB_W];
  assign in_range = pg_hi < (32-PB_W)'(NUM_PAGES);
  assign page_o   = wdata_i[PB_W +: PG_W];

  always_comb begin
    start_o = 1'b0;
    kind_o  = ER_PAGE;
    if (acc && we_i) begin
      unique case (addr_i)
        OFF_PG_A, OFF_PG_B: start_o = cfg_q[1] && in_range;
        OFF_CHIP: begin
          kind_o  = ER_CHIP;
          start_o = cfg_q[1] && (wdata_i == ERASE_KEY);
        end
        OFF_USER: begin
          kind_o  = ER_USER;
          start_o = (wdata_i == ERASE_KEY);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      rdata_o    <= '0;
      bad_acc_o  <= 1'b0;
      prog_err_o <= 1'b0;
    end else begin
      if (acc && we_i && (addr_i == OFF_CFG)) cfg_q <= wdata_i[1:0];
      if (acc && !we_i) begin
        unique case (addr_i)
          OFF_READY: rdata_o <= {31'b0, !busy_i};
          OFF_CFG:   rdata_o <= {30'b0, cfg_q};
          default:   rdata_o <= '0;
        endcase
      end
      if (acc && !known) bad_acc_o  <= 1'b1;
      if (prog_rej_i)    prog_err_o <= 1'b1;
    end
  end

  assign wen_o = cfg_q[0];
  assign een_o = cfg_q[1];
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
  import flash_ctl_pkg::*;
#(
  parameter int NUM_PAGES   = 8,
  parameter int PAGE_BYTES  = 1024,
  localparam int PAGE_WORDS  = PAGE_BYTES / 4,
  localparam int FLASH_WORDS = NUM_PAGES * PAGE_WORDS,
  localparam int FA_W        = $clog2(FLASH_WORDS),
  localparam int PG_W        = $clog2(NUM_PAGES),
  localparam int UA_W        = $clog2(UB_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_req_i,
  input  logic            reg_we_i,
  input  logic [7:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic            reg_rdy_o,
  output logic [31:0]     reg_rdata_o,
  input  logic            fl_req_i,
  input  logic            fl_we_i,
  input  logic [FA_W-1:0] fl_addr_i,
  input  logic [31:0]     fl_wdata_i,
  output logic            fl_rdy_o,
  output logic [31:0]     fl_rdata_o,
  input  logic            ub_req_i,
  input  logic            ub_we_i,
  input  logic [UA_W-1:0] ub_addr_i,
  input  logic [31:0]     ub_wdata_i,
  output logic            ub_rdy_o,
  output logic [31:0]     ub_rdata_o,
  output logic            bad_acc_o,
  output logic            prog_err_o
);
  logic            busy, wen, een, start;
  erase_kind_e     kind;
  logic [PG_W-1:0] page;
  logic            seq_fl_we, seq_ub_we;
  logic [FA_W-1:0] seq_fl_addr;
  logic [UA_W-1:0] seq_ub_addr;
  logic            fl_acc, ub_acc, prog_rej;

  flash_ctl_regs #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .prog_rej_i(prog_rej),
    .rdy_o(reg_rdy_o), .rdata_o(reg_rdata_o),
    .wen_o(wen), .een_o(een), .start_o(start), .kind_o(kind), .page_o(page),
    .bad_acc_o, .prog_err_o
  );

  flash_ctl_erase_seq #(.FLASH_WORDS(FLASH_WORDS), .PAGE_WORDS(PAGE_WORDS)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .kind_i(kind), .page_i(page),
    .busy_o(busy),
    .fl_we_o(seq_fl_we), .fl_addr_o(seq_fl_addr),
    .ub_we_o(seq_ub_we), .ub_addr_o(seq_ub_addr)
  );

  assign fl_rdy_o = !busy;
  assign ub_rdy_o = !busy;
  assign fl_acc   = fl_req_i && !busy;
  assign ub_acc   = ub_req_i && !busy;
  assign prog_rej = fl_acc && fl_we_i && !wen;

  flash_ctl_mem #(.WORDS(FLASH_WORDS), .RESET_ONES(1'b0)) u_flash (
    .clk_i, .rst_ni,
    .we_i   (seq_fl_we || (fl_acc && fl_we_i && wen)),
    .and_i  (!busy),
    .waddr_i(busy ? seq_fl_addr : fl_addr_i),
    .wdata_i(busy ? '1 : fl_wdata_i),
    .re_i   (fl_acc && !fl_we_i),
    .raddr_i(fl_addr_i),
    .rdata_o(fl_rdata_o)
  );

  flash_ctl_mem #(.WORDS(UB_WORDS), .RESET_ONES(1'b1)) u_ubank (
    .clk_i, .rst_ni,
    .we_i   (seq_ub_we || (ub_acc && ub_we_i)),
    .and_i  (1'b0),
    .waddr_i(busy ? seq_ub_addr : ub_addr_i),
    .wdata_i(busy ? '1 : ub_wdata_i),
    .re_i   (ub_acc && !ub_we_i),
    .raddr_i(ub_addr_i),
    .rdata_o(ub_rdata_o)
  );
endmodule

// File: rtl/flash_ctl_chk.sv
module flash_ctl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        wen_i,
  input logic        reg_req_i,
  input logic        reg_we_i,
  input logic [7:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        reg_rdy_o,
  input logic [31:0] reg_rdata_o,
  input logic        fl_req_i,
  input logic        fl_we_i,
  input logic        fl_rdy_o,
  input logic        ub_rdy_o,
  input logic        bad_acc_o,
  input logic        prog_err_o
);
  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (!fl_rdy_o && !ub_rdy_o));

  assert_ready_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_addr_i == 8'h00 && reg_rdy_o)
      |=> (reg_rdata_o == {31'b0, !$past(busy_i)}));

  assert_bad_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_acc_o |=> bad_acc_o);

  assert_prog_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_i && fl_we_i && fl_rdy_o && !wen_i) |=> prog_err_o);

  assert_fill_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(reg_req_i && reg_we_i && reg_rdy_o));

  assert_cfg_wen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && reg_addr_i == 8'h04 && reg_rdy_o)
      |=> (wen_i == $past(reg_wdata_i[0])));
endmodule

bind flash_ctl flash_ctl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .wen_i(wen),
  .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdy_o(reg_rdy_o), .reg_rdata_o(reg_rdata_o),
  .fl_req_i(fl_req_i), .fl_we_i(fl_we_i), .fl_rdy_o(fl_rdy_o),
  .ub_rdy_o(ub_rdy_o), .bad_acc_o(bad_acc_o), .prog_err_o(prog_err_o)
);

// File: tb/flash_ctl_bench.sv
module flash_ctl_bench;
  localparam int FA_W = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic             reg_req = 0, reg_we = 0;
  logic [7:0]       reg_addr = 0;
  logic [31:0]      reg_wdata = 0, reg_rdata;
  logic             reg_rdy;
  logic             fl_req = 0, fl_we = 0, fl_rdy;
  logic [FA_W-1:0]  fl_addr = 0;
  logic [31:0]      fl_wdata = 0, fl_rdata;
  logic             ub_req = 0, ub_we = 0, ub_rdy;
  logic [5:0]       ub_addr = 0;
  logic [31:0]      ub_wdata = 0, ub_rdata;
  logic             bad_acc, prog_err;

  flash_ctl u_flash_ctl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdy_o(reg_rdy), .reg_rdata_o(reg_rdata),
    .fl_req_i(fl_req), .fl_we_i(fl_we), .fl_addr_i(fl_addr),
    .fl_wdata_i(fl_wdata), .fl_rdy_o(fl_rdy), .fl_rdata_o(fl_rdata),
    .ub_req_i(ub_req), .ub_we_i(ub_we), .ub_addr_i(ub_addr),
    .ub_wdata_i(ub_wdata), .ub_rdy_o(ub_rdy), .ub_rdata_o(ub_rdata),
    .bad_acc_o(bad_acc), .prog_err_o(prog_err)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d act=%h exp=%h", req, act, exp);
    end
  endtask

  // port: 0 reg, 1 flash, 2 user bank; returns at the negedge after acceptance
  task automatic acc(input int port, input logic we, input logic [15:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    logic rdy;
    @(negedge clk);
    case (port)
      0: begin reg_req = 1; reg_we = we; reg_addr = a[7:0]; reg_wdata = d; end
      1: begin fl_req = 1; fl_we = we; fl_addr = a[FA_W-1:0]; fl_wdata = d; end
      default: begin ub_req = 1; ub_we = we; ub_addr = a[5:0]; ub_wdata = d; end
    endcase
    forever begin
      #1;
      rdy = (port == 0) ? reg_rdy : (port == 1) ? fl_rdy : ub_rdy;
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    q = (port == 0) ? reg_rdata : (port == 1) ? fl_rdata : ub_rdata;
    reg_req = 0; fl_req = 0; ub_req = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (!fl_rdy) begin
      n++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;   // 0 reg wr,1 reg rd,2 fl wr,3 fl rd,4 ub wr,5 ub rd
    logic [3:0]  req;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{3'd0, 4'd2, 16'h04,  32'hFFFF_FFFF, 32'h0},          // R2 upper bits dropped
    '{3'd1, 4'd2, 16'h04,  32'h0,         32'h0000_0003},  // R2
    '{3'd2, 4'd3, 16'd5,   32'hF0F0_FF00, 32'h0},          // R3
    '{3'd3, 4'd3, 16'd5,   32'h0,         32'hF0F0_FF00},  // R3
    '{3'd2, 4'd3, 16'd5,   32'h0FF0_F0F0, 32'h0},          // R3 AND
    '{3'd3, 4'd3, 16'd5,   32'h0,         32'h00F0_F000},  // R3
    '{3'd4, 4'd7, 16'd7,   32'h1234_5678, 32'h0},          // R7
    '{3'd5, 4'd7, 16'd7,   32'h0,         32'h1234_5678},  // R7
    '{3'd4, 4'd7, 16'd7,   32'hABCD_0000, 32'h0},          // R7 replace, no AND
    '{3'd5, 4'd7, 16'd7,   32'h0,         32'hABCD_0000},  // R7
    '{3'd3, 4'd5, 16'd300, 32'h0,         32'hFFFF_FFFF},  // R5 after chip erase
    '{3'd1, 4'd8, 16'h08,  32'h0,         32'h0}           // R8 write-only reads 0
  };

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog act=hung exp=done");
    summary();
  end

  initial begin
    logic [31:0] q;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(1, {31'b0, bad_acc}, 0);
    chk(1, {31'b0, prog_err}, 0);
    acc(0, 0, 16'h00, 0, q); chk(1, q, 32'h1);
    acc(0, 0, 16'h04, 0, q); chk(1, q, 32'h0);
    acc(2, 0, 16'd0, 0, q);  chk(1, q, 32'hFFFF_FFFF);
    acc(2, 0, 16'd63, 0, q); chk(1, q, 32'hFFFF_FFFF);

    // setup: enable both, chip erase, R10 duration
    acc(0, 1, 16'h04, 32'h3, q);
    acc(0, 1, 16'h10, 32'h1, q);
    count_busy(n); chk(10, n, 2048);

    for (int i = 0; i < 12; i++) begin
      int port;
      port = int'(VECS[i].op) / 2;
      acc(port, !VECS[i].op[0], VECS[i].addr, VECS[i].data, q);
      if (VECS[i].op[0]) chk(int'(VECS[i].req), q, VECS[i].exp);
    end
    chk(8, {31'b0, bad_acc}, 0);  // R8 defined offsets leave flag clear

    // R4 page erase with in-page bits, neighbours untouched
    acc(1, 1, 16'd255, 0, q); acc(1, 1, 16'd256, 0, q);
    acc(1, 1, 16'd511, 0, q); acc(1, 1, 16'd512, 0, q);
    acc(0, 1, 16'h08, 32'h0000_0523, q);
    count_busy(n); chk(10, n, 256);
    acc(1, 0, 16'd256, 0, q); chk(4, q, 32'hFFFF_FFFF);
    acc(1, 0, 16'd511, 0, q); chk(4, q, 32'hFFFF_FFFF);
    acc(1, 0, 16'd255, 0, q); chk(4, q, 32'h0);
    acc(1, 0, 16'd512, 0, q); chk(4, q, 32'h0);
    // R4 out-of-range page via second register
    acc(0, 1, 16'h0C, 32'h0000_2000, q);
    chk(4, {31'b0, fl_rdy}, 1);
    acc(1, 0, 16'd512, 0, q); chk(4, q, 32'h0);

    // R6 non-key ignored, key works with erase disabled; R9 ready reads 0
    acc(2, 1, 16'd3, 0, q);
    acc(0, 1, 16'h14, 32'h2, q);
    acc(2, 0, 16'd3, 0, q); chk(6, q, 32'h0);
    acc(0, 1, 16'h04, 32'h1, q);
    acc(0, 1, 16'h14, 32'h1, q);
    acc(0, 0, 16'h00, 0, q); chk(9, q, 32'h0);
    chk(9, {31'b0, ub_rdy}, 0);
    acc(2, 0, 16'd3, 0, q); chk(6, q, 32'hFFFF_FFFF);
    acc(0, 0, 16'h00, 0, q); chk(10, q, 32'h1);

    // R5 chip erase and R4 page erase ignored without erase enable
    acc(0, 1, 16'h10, 32'h1, q);
    chk(5, {31'b0, fl_rdy}, 1);
    acc(0, 1, 16'h08, 32'h0000_0800, q);
    acc(1, 0, 16'd512, 0, q); chk(4, q, 32'h0);

    // R3 program rejected when disabled
    chk(3, {31'b0, prog_err}, 0);
    acc(0, 1, 16'h04, 32'h2, q);
    acc(1, 1, 16'd600, 0, q);
    acc(1, 0, 16'd600, 0, q); chk(3, q, 32'hFFFF_FFFF);
    chk(3, {31'b0, prog_err}, 1);

    // R8 write to ready ignored; undefined offsets
    acc(0, 1, 16'h00, 32'h0, q);
    acc(0, 0, 16'h00, 0, q); chk(8, q, 32'h1);
    chk(8, {31'b0, bad_acc}, 0);
    acc(0, 0, 16'h18, 0, q); chk(8, q, 32'h0);
    chk(8, {31'b0, bad_acc}, 1);
    acc(0, 1, 16'h05, 32'h3, q);
    acc(0, 0, 16'h04, 0, q); chk(8, q, 32'h2);

    // R5 chip erase also clears user bank
    acc(2, 1, 16'd9, 0, q);
    acc(0, 1, 16'h10, 32'h1, q);
    count_busy(n); chk(10, n, 2048);
    acc(2, 0, 16'd9, 0, q);   chk(5, q, 32'hFFFF_FFFF);
    acc(1, 0, 16'd512, 0, q); chk(5, q, 32'hFFFF_FFFF);

    summary();
  end
endmodule